// File: doc/BRIEF.md
# Configurable Host Bus Front-End

This block sits between an external host processor bus and a small bank of internal registers. It accepts four bus styles through one set of pins. Two static mode inputs pick the style. The strobe mode chooses either two active-low read and write strobes, or a read/write direction line together with an active-low data strobe. The bus mode chooses either a separate 3-bit address bus or a 16-bit bus that carries the address and the data at different times, with an address-latch enable. A third static input narrows the data path to one byte.

The host control pins pass through a synchronizer into the core clock domain. Every access turns into clean single-cycle strobes toward the register bank. A read strobe marks the start of a host read. A write strobe follows the release of the host's strobe and carries a 3-bit register address and sized 16-bit data. Chip-select gates every access. The data pins are modelled as separate input, output and per-bit output-enable vectors. The bank's acknowledge is returned to the host only while an access is in progress.

Top module: `hostbus_frontend`

## Requirements
- R1: With strobe mode 0, `ctl_a_i` is an active-low read strobe and `ctl_b_i` is an active-low write strobe. One low period of `ctl_b_i` under chip-select produces one `reg_wr_o` pulse carrying the written data.
- R2: With strobe mode 1, `ctl_a_i` selects the direction (1 = read, 0 = write) and `ctl_b_i` is an active-low data strobe. A data strobe with direction 0 writes, and a data strobe with direction 1 reads.
- R3: With bus mode 0, the register address is `{a2_ale_i, a_lo_i[1:0]}`, taken when the access begins.
- R4: With bus mode 1, `a2_ale_i` is the address-latch enable. On its falling edge, bits 2:0 of `data_in_i` become the register address. Bits 15:3 of the bus and the `a_lo_i` pins are ignored. The address holds until the next latch pulse.
- R5: With `narrow_i` = 1, write data reaches the bank as `{8'h00, data_in_i[7:0]}`.
- R6: With `narrow_i` = 1, a read drives only bits 7:0. Enables 15:8 stay 0, and bits 7:0 carry bank bits 7:0.
- R7: While `cs_n_i` is high, strobe activity has no effect: no `reg_wr_o`, no `reg_rd_o`, no output enable and no acknowledge.
- R8: `data_oe_o` is non-zero only during an active read. It is all-zero during writes and when the bus is idle.
- R9: A write access gives exactly one `reg_wr_o` pulse, one cycle wide, issued after the host's active strobe is released.
- R10: `ack_o` equals `bank_ack_i` while an access is active and is 0 otherwise.
- R11: After reset, `reg_wr_o`, `reg_rd_o`, `ack_o`, `data_oe_o` and `reg_addr_o` are all zero.
- R12: A read access gives exactly one `reg_rd_o` pulse. While the read is active in 16-bit mode, `data_out_o` presents `reg_rdata_i` on all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_mode_i | input | 1 | 0: read/write strobes, 1: direction plus data strobe |
| muxed_mode_i | input | 1 | 0: separate address bus, 1: multiplexed address/data |
| narrow_i | input | 1 | 1: 8-bit host data |
| cs_n_i | input | 1 | Active-low chip select |
| ctl_a_i | input | 1 | Read strobe (mode 0) or direction line (mode 1) |
| ctl_b_i | input | 1 | Write strobe (mode 0) or data strobe (mode 1) |
| a2_ale_i | input | 1 | Address bit 2, or address-latch enable in multiplexed mode |
| a_lo_i | input | 2 | Address bits 1:0, unused in multiplexed mode |
| data_in_i | input | 16 | Host bus value seen at the pins |
| data_out_o | output | 16 | Value driven onto the host bus |
| data_oe_o | output | 16 | Per-bit output enable for the host bus |
| ack_o | output | 1 | Acknowledge to the host |
| reg_addr_o | output | 3 | Register address toward the bank |
| reg_wdata_o | output | 16 | Sized write data toward the bank |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 16 | Read data from the bank |
| bank_ack_i | input | 1 | Acknowledge from the bank |

## Verification
The hardest case to reach is the multiplexed address phase. The address must be taken from the synchronized falling edge of the latch enable, and it must survive the data phase on the same pins. The stimulus puts an address on the bus with bits 15:3 all set and the low address pins at a contrary value. It then drops the latch enable, replaces the bus value with write data, and checks both the write address and the register address that persists afterwards. Chip-select gating is reached by running complete strobe sequences with chip-select high. The bench then observes the strobe counters, the enables and the acknowledge.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_ADDR_W = 3;
  localparam int HB_DATA_W = 16;
  localparam int HB_LANE_W = 8;

  typedef enum logic {
    STB_SPLIT = 1'b0,
    STB_RWDS  = 1'b1
  } strobe_sel_e;

  typedef enum logic {
    BUS_SEPARATE = 1'b0,
    BUS_MUXED    = 1'b1
  } bus_sel_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_mode_i,
  input  logic cs_n_s_i,
  input  logic ctl_a_s_i,
  input  logic ctl_b_s_i,
  output logic rd_act_o,
  output logic wr_act_o,
  output logic acc_act_o,
  output logic acc_start_o,
  output logic rd_pulse_o,
  output logic wr_pulse_o
);
  logic rd_q, wr_q, rd_pulse_q, wr_pulse_q;
  logic rd_d, wr_d, rd_pulse_d, wr_pulse_d;
  logic sel;

  assign sel = ~cs_n_s_i;

  always_comb begin
    if (strobe_sel_e'(strobe_mode_i) == STB_SPLIT) begin
      rd_act_o = sel & ~ctl_a_s_i;
      wr_act_o = sel & ~ctl_b_s_i;
    end else begin
      rd_act_o = sel & ~ctl_b_s_i & ctl_a_s_i;
      wr_act_o = sel & ~ctl_b_s_i & ~ctl_a_s_i;
    end
  end

  assign acc_act_o   = rd_act_o | wr_act_o;
  assign acc_start_o = acc_act_o & ~(rd_q | wr_q);

  always_comb begin
    rd_d       = rd_act_o;
    wr_d       = wr_act_o;
    rd_pulse_d = rd_act_o & ~rd_q;
    wr_pulse_d = wr_q & ~wr_act_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      rd_pulse_q <= 1'b0;
      wr_pulse_q <= 1'b0;
    end else begin
      rd_q       <= rd_d;
      wr_q       <= wr_d;
      rd_pulse_q <= rd_pulse_d;
      wr_pulse_q <= wr_pulse_d;
    end
  end

  assign rd_pulse_o = rd_pulse_q;
  assign wr_pulse_o = wr_pulse_q;

  // R9: a write strobe never lasts two cycles
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |=> !wr_pulse_o);
  // R12: a read strobe never lasts two cycles
  p_rd_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_o |=> !rd_pulse_o);
endmodule

// File: rtl/hb_addr_latch.sv
module hb_addr_latch
  import hb_pkg::*;
#(
  parameter int ADDR_W = HB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              muxed_i,
  input  logic              acc_start_i,
  input  logic              ale_s_i,
  input  logic [ADDR_W-1:0] sep_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, shadow_q, shadow_d;
  logic ale_q, ale_fall;

  assign ale_fall = ale_q & ~ale_s_i;

  always_comb begin
    addr_d   = addr_q;
    shadow_d = shadow_q;
    if (bus_sel_e'(muxed_i) == BUS_MUXED) begin
      if (ale_s_i)  shadow_d = bus_addr_i;
      if (ale_fall) addr_d   = shadow_q;
    end else if (acc_start_i) begin
      addr_d = sep_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      shadow_q <= '0;
      ale_q    <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      shadow_q <= shadow_d;
      ale_q    <= ale_s_i;
    end
  end

  assign addr_o = addr_q;

  // R4: without a latch-enable fall the multiplexed address holds
  p_mux_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (muxed_i && !ale_fall) |=> $stable(addr_o));
endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int DATA_W = HB_DATA_W,
  parameter int LANE_W = HB_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_i,
  input  logic              wr_act_i,
  input  logic              rd_act_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] oe_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] hold_q, hold_d;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      logic lane_on;
      if (l == 0) begin : g_low
        assign lane_on = 1'b1;
      end else begin : g_high
        assign lane_on = ~narrow_i;
      end
      assign dout_o[l*LANE_W +: LANE_W] = lane_on ? rdata_i[l*LANE_W +: LANE_W] : '0;
      assign oe_o[l*LANE_W +: LANE_W]   = {LANE_W{rd_act_i & lane_on}};
      always_comb begin
        hold_d[l*LANE_W +: LANE_W] = hold_q[l*LANE_W +: LANE_W];
        if (wr_act_i)
          hold_d[l*LANE_W +: LANE_W] = lane_on ? din_i[l*LANE_W +: LANE_W] : '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign wdata_o = hold_q;
endmodule

// File: rtl/hostbus_frontend.sv
module hostbus_frontend
  import hb_pkg::*;
#(
  parameter int ADDR_W      = HB_ADDR_W,
  parameter int DATA_W      = HB_DATA_W,
  parameter int LANE_W      = HB_LANE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_mode_i,
  input  logic              muxed_mode_i,
  input  logic              narrow_i,
  input  logic              cs_n_i,
  input  logic              ctl_a_i,
  input  logic              ctl_b_i,
  input  logic              a2_ale_i,
  input  logic [1:0]        a_lo_i,
  input  logic [DATA_W-1:0] data_in_i,
  output logic [DATA_W-1:0] data_out_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              bank_ack_i
);
  localparam int CTL_W = 4;

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  assign ctl_raw = {cs_n_i, ctl_a_i, ctl_b_i, a2_ale_i};

  hb_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .IDLE(4'b1110)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  logic rd_act, wr_act, acc_act, acc_start, rd_pulse, wr_pulse;

  hb_decode u_decode (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .strobe_mode_i (strobe_mode_i),
    .cs_n_s_i      (ctl_s[3]),
    .ctl_a_s_i     (ctl_s[2]),
    .ctl_b_s_i     (ctl_s[1]),
    .rd_act_o      (rd_act),
    .wr_act_o      (wr_act),
    .acc_act_o     (acc_act),
    .acc_start_o   (acc_start),
    .rd_pulse_o    (rd_pulse),
    .wr_pulse_o    (wr_pulse)
  );

  hb_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .muxed_i     (muxed_mode_i),
    .acc_start_i (acc_start),
    .ale_s_i     (ctl_s[0]),
    .sep_addr_i  ({a2_ale_i, a_lo_i}),
    .bus_addr_i  (data_in_i[ADDR_W-1:0]),
    .addr_o      (reg_addr_o)
  );

  hb_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .narrow_i (narrow_i),
    .wr_act_i (wr_act),
    .rd_act_i (rd_act),
    .din_i    (data_in_i),
    .rdata_i  (reg_rdata_i),
    .wdata_o  (reg_wdata_o),
    .dout_o   (data_out_o),
    .oe_o     (data_oe_o)
  );

  assign reg_wr_o = wr_pulse;
  assign reg_rd_o = rd_pulse;
  assign ack_o    = acc_act & bank_ack_i;

  // R10: no acknowledge to the host outside an access
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !acc_act |-> !ack_o);
  // R8: bus never driven in the cycle a write is handed to the bank
  p_oe_not_on_write_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    reg_wr_o |-> (data_oe_o == '0) || rd_act);
  // R5: narrow writes reach the bank with a clear upper byte
  p_narrow_wdata_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr_o && narrow_i && $stable(narrow_i)) |-> (reg_wdata_o[DATA_W-1:LANE_W] == '0));
  // R6: upper lane stays released for a narrow host
  p_narrow_oe_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    narrow_i |-> (data_oe_o[DATA_W-1:LANE_W] == '0));
endmodule

// File: tb/tb_hostbus_frontend.sv
module tb_hostbus_frontend;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, strobe_mode, muxed_mode, narrow, cs_n, ctl_a, ctl_b, a2_ale, bank_ack;
  logic [1:0]  a_lo;
  logic [15:0] data_in, data_out, data_oe, reg_wdata, reg_rdata;
  logic [2:0]  reg_addr;
  logic        ack, reg_wr, reg_rd;

  hostbus_frontend dut (
    .clk(clk), .rst_n(rst_n), .strobe_mode_i(strobe_mode), .muxed_mode_i(muxed_mode),
    .narrow_i(narrow), .cs_n_i(cs_n), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b),
    .a2_ale_i(a2_ale), .a_lo_i(a_lo), .data_in_i(data_in), .data_out_o(data_out),
    .data_oe_o(data_oe), .ack_o(ack), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata), .bank_ack_i(bank_ack)
  );

  function automatic logic [15:0] bank_val(input logic [2:0] a);
    return 16'hC3A0 ^ {13'h0, a} ^ {a, 13'h0};
  endfunction
  assign reg_rdata = bank_val(reg_addr);

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [2:0]  last_wa;
  logic [15:0] last_wd;

  always @(posedge clk) begin
    if (reg_wr) begin wr_cnt <= wr_cnt + 1; last_wa <= reg_addr; last_wd <= reg_wdata; end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; ctl_a = 1'b1; ctl_b = 1'b1; a2_ale = 1'b0; a_lo = 2'b00; data_in = 16'h0;
  endtask

  task automatic addr_phase(input logic [2:0] a);
    if (muxed_mode) begin
      a_lo = ~a[1:0];
      data_in = 16'hFFF8 | {13'h0, a};
      a2_ale = 1'b1; wait_n(3);
      a2_ale = 1'b0; wait_n(4);
    end else begin
      a2_ale = a[2]; a_lo = a[1:0];
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d, input bit sel);
    addr_phase(a);
    data_in = d;
    cs_n = ~sel; wait_n(1);
    if (strobe_mode) begin ctl_a = 1'b0; wait_n(1); end
    ctl_b = 1'b0; wait_n(5);
    ctl_b = 1'b1; wait_n(5);
    cs_n = 1'b1; ctl_a = 1'b1; wait_n(3);
  endtask

  task automatic host_read(input logic [2:0] a, input bit sel,
                           output logic [15:0] oe, output logic [15:0] dout, output logic ak);
    addr_phase(a);
    cs_n = ~sel; wait_n(1);
    if (strobe_mode) begin ctl_a = 1'b1; ctl_b = 1'b0; end
    else ctl_a = 1'b0;
    wait_n(6);
    oe = data_oe; dout = data_out; ak = ack;
    ctl_a = 1'b1; ctl_b = 1'b1; wait_n(5);
    cs_n = 1'b1; wait_n(3);
  endtask

  task automatic t_reset();
    chk(reg_wr == 0 && reg_rd == 0 && ack == 0, "R11 strobes/ack", {reg_wr, reg_rd, ack}, 0);
    chk(data_oe == 16'h0, "R11 oe", data_oe, 0);
    chk(reg_addr == 3'd0, "R11 addr", reg_addr, 0);
  endtask

  task automatic t_split_separate();
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 0; muxed_mode = 0; narrow = 0;
    host_write(3'd5, 16'hBEEF, 1'b1);
    chk(wr_cnt == w0 + 1, "R1 R9 one write pulse", wr_cnt - w0, 1);
    chk(last_wa == 3'd5, "R3 write address", last_wa, 5);
    chk(last_wd == 16'hBEEF, "R1 write data", last_wd, 16'hBEEF);
    chk(data_oe == 16'h0, "R8 oe idle after write", data_oe, 0);
    host_read(3'd3, 1'b1, oe, dout, ak);
    chk(oe == 16'hFFFF, "R8 oe during read", oe, 16'hFFFF);
    chk(dout == bank_val(3'd3), "R12 read data", dout, bank_val(3'd3));
    chk(rd_cnt == r0 + 1, "R12 one read pulse", rd_cnt - r0, 1);
    chk(wr_cnt == w0 + 1, "R9 read gives no write", wr_cnt - w0, 1);
    chk(data_oe == 16'h0, "R8 oe released", data_oe, 0);
  endtask

  task automatic t_rwds();
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 1; muxed_mode = 0; narrow = 0;
    host_write(3'd6, 16'h1234, 1'b1);
    chk(wr_cnt == w0 + 1 && last_wd == 16'h1234, "R2 strobe write", last_wd, 16'h1234);
    chk(last_wa == 3'd6, "R2 R3 write address", last_wa, 6);
    host_read(3'd1, 1'b1, oe, dout, ak);
    chk(oe == 16'hFFFF && dout == bank_val(3'd1), "R2 strobe read", dout, bank_val(3'd1));
    chk(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R2 read not write", rd_cnt - r0, 1);
  endtask

  task automatic t_muxed();
    int w0 = wr_cnt;
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 0; muxed_mode = 1; narrow = 0;
    host_write(3'd2, 16'h55AA, 1'b1);
    chk(wr_cnt == w0 + 1 && last_wa == 3'd2, "R4 latched address", last_wa, 2);
    chk(last_wd == 16'h55AA, "R4 data phase", last_wd, 16'h55AA);
    data_in = 16'h0007; a_lo = 2'b11; wait_n(4);
    chk(reg_addr == 3'd2, "R4 address held", reg_addr, 2);
    strobe_mode = 1;
    host_read(3'd7, 1'b1, oe, dout, ak);
    chk(dout == bank_val(3'd7), "R4 read after latch", dout, bank_val(3'd7));
  endtask

  task automatic t_narrow();
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 0; muxed_mode = 0; narrow = 1;
    host_write(3'd4, 16'hABCD, 1'b1);
    chk(last_wd == 16'h00CD, "R5 zero fill", last_wd, 16'h00CD);
    host_read(3'd4, 1'b1, oe, dout, ak);
    chk(oe == 16'h00FF, "R6 low lane only", oe, 16'h00FF);
    chk(dout[7:0] == bank_val(3'd4)[7:0], "R6 low byte", dout[7:0], bank_val(3'd4)[7:0]);
    narrow = 0;
  endtask

  task automatic t_deselected();
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 0; muxed_mode = 0;
    host_write(3'd1, 16'hDEAD, 1'b0);
    chk(wr_cnt == w0, "R7 no write without select", wr_cnt - w0, 0);
    host_read(3'd1, 1'b0, oe, dout, ak);
    chk(oe == 16'h0 && ak == 1'b0, "R7 no drive or ack", {oe, 15'h0, ak}, 0);
    chk(rd_cnt == r0, "R7 no read without select", rd_cnt - r0, 0);
  endtask

  task automatic t_ack();
    logic [15:0] oe, dout; logic ak;
    strobe_mode = 0; muxed_mode = 0;
    bank_ack = 1'b0;
    host_read(3'd0, 1'b1, oe, dout, ak);
    chk(ak == 1'b0, "R10 ack follows bank low", ak, 0);
    bank_ack = 1'b1;
    host_read(3'd0, 1'b1, oe, dout, ak);
    chk(ak == 1'b1, "R10 ack follows bank high", ak, 1);
    chk(ack == 1'b0, "R10 ack idle", ack, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_mode = 0; muxed_mode = 0; narrow = 0; bank_ack = 1'b1;
    idle_pins();
    wait_n(5);
    rst_n = 1'b1;
    wait_n(6);
    t_reset();
    t_split_separate();
    t_rwds();
    t_muxed();
    t_narrow();
    t_deselected();
    t_ack();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule